// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a memory-mapped watchdog timer on a simple 32-bit write bus with a combinational read port. Software sets up a reload value and a clock divider, then enables the timer. From then on it must periodically write a magic value to the restart register. If it stops doing so, a down counter runs out. The block then raises an interrupt, sends out a reset pulse of programmable length, or both.

Each configuration register accepts a write only when the word carries that register's own access key. A stray store to the block's address range therefore cannot reconfigure or disable the watchdog. The counter is 12 + `CNT_LOW_W` bits wide. It is loaded with the 12-bit reload field above an all-ones low part, so the reload field sets the timeout in coarse steps of 2^`CNT_LOW_W` divided ticks. The only way to reach a timeout is for the counter to run down; there is no way to force an immediate expiry.

Top module: `keyed_wdt`

## Requirements
- R1: The bus word index selects the register: 0 is mode, 1 is counter control, 2 is restart and 3 is status. Mode reads back as {en at bit 0, reset enable at bit 1, irq enable at bit 2, pulse-length code at bits 5:4}. Control reads back as {reload at bits 13:2, divider select at bits 1:0}. Status reads back the expiry flag at bit 0. Restart reads as zero, and every other bit reads as zero.
- R2: A mode write takes effect only when data bits 23:12 equal 0xABC. Otherwise all mode fields keep their values.
- R3: A control write takes effect only when data bits 25:14 equal 0x248, which is the word 0x00920000. Otherwise the reload and select fields keep their values.
- R4: Writing exactly 0x00001999 to the restart register loads the counter with {reload, all ones} and clears the expiry flag. Any other value has no effect.
- R5: A mode write that takes the enable bit from 0 to 1 loads the counter in the same way as R4.
- R6: Divider select codes 0, 1, 2 and 3 divide the clock by 8, 64, 512 and 4096. The counter decrements once per divided tick. Expiry occurs exactly (reload·2^CNT_LOW_W + 2^CNT_LOW_W − 1)·divisor clock edges after the loading edge.
- R7: While the enable bit is 0, the counter holds its value and no expiry occurs.
- R8: When the counter reaches zero, the expiry flag is set. The flag and the zero count hold until the next load.
- R9: `wdt_irq` is a level that is high exactly while the expiry flag and the irq enable are both set.
- R10: If reset enable is set at expiry, `wdt_rst` goes high at the expiry edge. It stays high for 2, 4, 8 or 16 cycles for pulse-length codes 0, 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_rst | output | 1 | Reset pulse on expiry |
| wdt_irq | output | 1 | Level interrupt on expiry |

## Verification
The bench measures expiry to the exact edge for all four divider codes. A design with an off-by-one in the divider or the load value would raise the interrupt one or more cycles early or late. It writes each register with correct and slightly wrong keys and reads the fields back. A design that compared too few key bits would then show altered fields. It also sends a restart value that is one off in the middle of a countdown. An unkeyed restart would delay the expiry, and the bench would see the late interrupt. Finally, it checks the reset pulse width for all four length codes, checks that the timeout is held after expiry, and checks that no timeout happens while the timer is disabled.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int CNT_LOW_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst,
  output logic        wdt_irq
);
  localparam int RLD_W = 12;
  localparam int CNT_W = RLD_W + CNT_LOW_W;
  localparam int PRE_W = 12;

  logic             en, rst_en, irq_en;
  logic [1:0]       len;
  logic [RLD_W-1:0] reload;
  logic [1:0]       sel;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre, mask;
  logic             expired;
  logic [4:0]       pulse;

  wire mode_ok = bus_wr && bus_addr == 2'd0 && bus_wdata[23:12] == 12'hABC;
  wire ctrl_ok = bus_wr && bus_addr == 2'd1 && bus_wdata[25:14] == 12'h248;
  wire kick    = bus_wr && bus_addr == 2'd2 && bus_wdata == 32'h0000_1999;
  wire load    = kick || (mode_ok && bus_wdata[0] && !en);
  wire tick    = en && pre == mask;
  wire hit     = !load && tick && cnt == CNT_W'(1);

  always_comb
    case (sel)
      2'd0: mask = PRE_W'(7);
      2'd1: mask = PRE_W'(63);
      2'd2: mask = PRE_W'(511);
      default: mask = PRE_W'(4095);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en, rst_en, irq_en, len} <= '0;
      reload <= '0;
      sel    <= '0;
    end else begin
      if (mode_ok) {len, irq_en, rst_en, en} <= {bus_wdata[5:4], bus_wdata[2:0]};
      if (ctrl_ok) {reload, sel} <= bus_wdata[13:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt     <= '0;
      pre     <= '0;
      expired <= 1'b0;
    end else if (load) begin
      cnt     <= {reload, {CNT_LOW_W{1'b1}}};
      pre     <= '0;
      expired <= 1'b0;
    end else begin
      pre <= (!en || tick) ? '0 : pre + 1'b1;
      if (tick && cnt != '0) cnt <= cnt - 1'b1;
      if (hit) expired <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              pulse <= '0;
    else if (hit && rst_en)  pulse <= 5'(2 << len);
    else if (pulse != '0)    pulse <= pulse - 1'b1;

  assign wdt_rst = pulse != '0;
  assign wdt_irq = expired && irq_en;

  always_comb
    case (bus_addr)
      2'd0: bus_rdata = {26'b0, len, 1'b0, irq_en, rst_en, en};
      2'd1: bus_rdata = {18'b0, reload, sel};
      2'd2: bus_rdata = '0;
      default: bus_rdata = {31'b0, expired};
    endcase

  p_mode_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[23:12] != 12'hABC)
      |=> $stable({en, rst_en, irq_en, len}));

  p_ctrl_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && bus_wdata[25:14] != 12'h248)
      |=> $stable({reload, sel}));

  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt));

  p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  p_expiry_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> (expired && cnt == '0));

  p_pulse_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> $rose(expired));
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam int CLK_NS = 10;
  localparam int LOW_W  = 4;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst, wdt_irq;
  int          cyc = 0, t0 = 0, tests = 0, fails = 0;
  bit          done = 0;

  keyed_wdt #(.CNT_LOW_W(LOW_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst(wdt_rst), .wdt_irq(wdt_irq));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {word index, write data, expected readback}
  localparam logic [65:0] VEC [6] = '{
    {2'd1, 32'h0092_0015, 32'h0000_0015},
    {2'd1, 32'h0091_001E, 32'h0000_0015},
    {2'd1, 32'h0092_3FFF, 32'h0000_3FFF},
    {2'd0, 32'h00AB_C032, 32'h0000_0032},
    {2'd0, 32'h00AB_D007, 32'h0000_0032},
    {2'd0, 32'h00AB_C004, 32'h0000_0004}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    t0 = cyc;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) begin @(posedge clk); #1; end
  endtask

  task automatic timeout_run(input int rl, input int sel, input string tag);
    int k;
    logic [31:0] d;
    k = (rl * (1 << LOW_W) + (1 << LOW_W) - 1) * (8 << (3 * sel));
    wr(2'd0, 32'h00AB_C000);
    wr(2'd1, 32'h0092_0000 | (rl << 2) | sel);
    wr(2'd0, 32'h00AB_C005);
    wait_to(t0 + k - 1);
    chk(wdt_irq, 1'b0, {tag, " early"});
    wait_to(t0 + k);
    chk(wdt_irq, 1'b1, {tag, " on time"});
    rd(2'd3, d);
    chk(d, 32'h1, {tag, " status"});
  endtask

  task automatic pulse_chk(input int k, input int l, input string tag);
    wait_to(t0 + k - 1);
    chk(wdt_rst, 1'b0, {tag, " before"});
    wait_to(t0 + k);
    chk(wdt_rst, 1'b1, {tag, " first"});
    wait_to(t0 + k + l - 1);
    chk(wdt_rst, 1'b1, {tag, " last"});
    wait_to(t0 + k + l);
    chk(wdt_rst, 1'b0, {tag, " end"});
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), d);
      chk(d, 32'h0, "R1 reset readback");
    end
    chk({wdt_rst, wdt_irq}, 2'b00, "R1 reset outputs");

    // R2 R3 key-gated writes from the table
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][65:64], VEC[i][63:32]);
      rd(VEC[i][65:64], d);
      chk(d, VEC[i][31:0], (VEC[i][65:64] == 2'd0) ? "R2 mode key" : "R3 ctrl key");
    end

    // R5 R6 R9: enable-rise load, divide by 8
    timeout_run(1, 0, "R6 sel0");
    // R8 held after expiry
    repeat (100) @(posedge clk); #1;
    chk(wdt_irq, 1'b1, "R8 expiry held");

    // R4 restart clears, wrong key ignored mid-count
    wr(2'd2, 32'h0000_1999);
    chk(wdt_irq, 1'b0, "R4 restart clears irq");
    begin
      int s;
      s = t0;
      wait_to(s + 50);
      wr(2'd2, 32'h0000_1998);
      wait_to(s + 247);
      chk(wdt_irq, 1'b0, "R4 bad key early");
      wait_to(s + 248);
      chk(wdt_irq, 1'b1, "R4 bad key ignored");
    end

    timeout_run(0, 1, "R6 sel1");
    timeout_run(0, 2, "R6 sel2");
    timeout_run(0, 3, "R6 sel3");

    // R7 disabled: no timeout
    wr(2'd0, 32'h00AB_C004);
    wr(2'd2, 32'h0000_1999);
    repeat (300) @(posedge clk); #1;
    chk(wdt_irq, 1'b0, "R7 disabled irq");
    rd(2'd3, d);
    chk(d, 32'h0, "R7 disabled status");

    // R10 pulse lengths
    wr(2'd1, 32'h0092_0001);
    wr(2'd0, 32'h00AB_C013);
    pulse_chk(15 * 64, 4, "R10 code1");
    chk(wdt_irq, 1'b0, "R9 irq disabled");
    wr(2'd0, 32'h00AB_C000);
    wr(2'd1, 32'h0092_0000);
    wr(2'd0, 32'h00AB_C033);
    pulse_chk(120, 16, "R10 code3");
    wr(2'd0, 32'h00AB_C003);
    wr(2'd2, 32'h0000_1999);
    pulse_chk(120, 2, "R10 code0");
    wr(2'd0, 32'h00AB_C023);
    wr(2'd2, 32'h0000_1999);
    pulse_chk(120, 8, "R10 code2");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule